// File: doc/BRIEF.md
# Serial Configuration Loader with Daisy-Chain Forwarding

This block receives a device's configuration as a stream of single bits on a data input. Each bit is qualified by a rising edge of a configuration clock. Three mode pins choose the clocking role. In follower mode the configuration clock comes in from outside. In leader mode the block makes that clock itself by dividing the system clock. All logic runs on the system clock. An external configuration clock is synchronised and its rising edges are detected, and the data input goes through the same delay so that it stays aligned with its edge.

The first `LOAD_BITS` bits are shifted into a local configuration word. When the last of them arrives, a done flag rises and the word is frozen. Every later bit is sent to a downstream data output on the same rising edge that captures it, so that devices further along a chain are loaded in turn. In leader mode the generated clock always starts at a slow rate. One bit at a fixed position in the stream can ask for a fast rate. The new divide value is applied only at the start of a low phase, so no shortened pulse can appear.

The stream is a plain clocked serial line with no valid/ready handshake. The bit-qualifying clock edge acts as the only valid strobe. The sender cannot be stalled, so the receiver accepts one bit on every rising edge.

Top module: `cfgload_top`

## Requirements
- R1: Mode pins 3'b000 select leader mode: `cclk_oe` is 1 and `cclk_out` toggles. Every other code selects follower mode, including 3'b111, which is the value weak pull-ups give undriven pins. In follower mode `cclk_oe` is 0 and `cclk_out` stays 0, whatever bits are received.
- R2: In follower mode a bit is taken from `din` on each rising edge of `cclk_in`. Bits enter `cfg_word` at bit 0 and shift towards the MSB, so the first bit received ends up in bit `LOAD_BITS-1`.
- R3: `load_done` is 0 until exactly `LOAD_BITS` bits have been captured. It rises on the capture of bit number `LOAD_BITS` and stays 1 until reset.
- R4: `dout` is 0 while `load_done` is 0. After `load_done` rises, `cfg_word` no longer changes, and each further bit captured on a rising configuration edge appears on `dout` and is held until the next rising edge.
- R5: In leader mode the high and low phases of `cclk_out` each last `SLOW_HALF` system cycles until a rate change is applied.
- R6: The bit at arrival index `FAST_BIT_IDX` (counting from 0) is the rate bit. If it is 1, every phase that starts after the next falling edge of `cclk_out` lasts `FAST_HALF` cycles. If it is 0, the rate stays slow.
- R7: The rate select changes only at a falling edge of `cclk_out`, and no phase of `cclk_out` is shorter than `FAST_HALF` system cycles.
- R8: Synchronous reset clears the bit counter, `cfg_word`, `load_done`, `dout`, the rate select and `cclk_out`. After reset, leader mode starts again at the slow rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_pins | input | 3 | Clocking role select (000 leader, any other code follower) |
| cclk_in | input | 1 | Configuration clock from outside, used in follower mode |
| din | input | 1 | Serial configuration data |
| cclk_out | output | 1 | Generated configuration clock in leader mode, otherwise 0 |
| cclk_oe | output | 1 | 1 when this block drives the configuration clock |
| dout | output | 1 | Bits forwarded to the next device in the chain |
| load_done | output | 1 | Local configuration word complete |
| cfg_word | output | LOAD_BITS | Captured configuration word, first bit in the MSB |

## Verification
The rate switch is the hardest state to reach. It can only occur in leader mode, after the rate bit has arrived at the right index, and only at a falling edge of a clock that the block makes itself. For that reason the leader-mode stimulus does not run on a fixed schedule. It follows `cclk_out`: it places each bit during the low phase and counts the length of each high phase. With this, the bench can confirm that the high phase carrying the rate bit is still slow and that the next one is fast. A stream whose rate bit is 0, and a reset in the middle of a fast load, show the two ways of staying at, or going back to, the slow rate.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

  typedef enum logic [0:0] {
    ROLE_FOLLOWER = 1'b0,
    ROLE_LEADER   = 1'b1
  } clk_role_e;

  // Only an all-zero pin code makes this block drive the clock; pulled-up
  // (all-ones) or any other code leaves it a clock follower.
  function automatic clk_role_e role_of(input logic [2:0] pins);
    return (pins == 3'b000) ? ROLE_LEADER : ROLE_FOLLOWER;
  endfunction

endpackage

// File: rtl/cfgload_mode_dec.sv
module cfgload_mode_dec
  import cfgload_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_pins,
  output clk_role_e  role
);

  always_ff @(posedge clk) begin
    if (rst) role <= ROLE_FOLLOWER;
    else     role <= role_of(mode_pins);
  end

endmodule

// File: rtl/cfgload_clkgen.sv
module cfgload_clkgen #(
  parameter int SLOW_HALF = 8,
  parameter int FAST_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast_req,
  output logic cclk,
  output logic rise,
  output logic fast_sel
);

  localparam int MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int CW   = $clog2(MAXH) + 1;

  logic [CW-1:0] div_cnt;
  logic [CW-1:0] half_lim;

  assign half_lim = fast_sel ? CW'(FAST_HALF - 1) : CW'(SLOW_HALF - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt  <= '0;
      cclk     <= 1'b0;
      rise     <= 1'b0;
      fast_sel <= 1'b0;
    end else if (!run) begin
      div_cnt <= '0;
      cclk    <= 1'b0;
      rise    <= 1'b0;
    end else begin
      rise <= 1'b0;
      if (div_cnt == half_lim) begin
        div_cnt <= '0;
        cclk    <= ~cclk;
        if (!cclk) rise     <= 1'b1;
        else       fast_sel <= fast_req;  // applied as a low phase begins
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfgload_edge.sv
module cfgload_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic leader,
  input  logic gen_rise,
  input  logic cclk_in,
  input  logic din,
  output logic bit_stb,
  output logic bit_val
);

  logic [SYNC_STAGES:0]   clk_pipe;
  logic [SYNC_STAGES-1:0] dat_pipe;
  logic                   ext_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_pipe <= '0;
      dat_pipe <= '0;
    end else begin
      clk_pipe <= {clk_pipe[SYNC_STAGES-1:0], cclk_in};
      dat_pipe <= {dat_pipe[SYNC_STAGES-2:0], din};
    end
  end

  assign ext_rise = clk_pipe[SYNC_STAGES-1] & ~clk_pipe[SYNC_STAGES];

  always_comb begin
    if (leader) begin
      bit_stb = gen_rise;
      bit_val = din;
    end else begin
      bit_stb = ext_rise;
      bit_val = dat_pipe[SYNC_STAGES-1];
    end
  end

endmodule

// File: rtl/cfgload_shifter.sv
module cfgload_shifter #(
  parameter int LOAD_BITS    = 16,
  parameter int FAST_BIT_IDX = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_stb,
  input  logic                 bit_val,
  output logic [LOAD_BITS-1:0] word,
  output logic                 done,
  output logic                 dout,
  output logic                 fast_req
);

  localparam int CNTW = $clog2(LOAD_BITS + 1);

  logic [CNTW-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      word     <= '0;
      done     <= 1'b0;
      dout     <= 1'b0;
      fast_req <= 1'b0;
    end else if (bit_stb) begin
      if (!done) begin
        word    <= {word[LOAD_BITS-2:0], bit_val};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNTW'(FAST_BIT_IDX) && bit_val) fast_req <= 1'b1;
        if (bit_cnt == CNTW'(LOAD_BITS - 1))            done     <= 1'b1;
      end else begin
        dout <= bit_val;
      end
    end
  end

endmodule

// File: rtl/cfgload_top.sv
module cfgload_top
  import cfgload_pkg::*;
#(
  parameter int LOAD_BITS    = 16,
  parameter int FAST_BIT_IDX = 3,
  parameter int SLOW_HALF    = 8,
  parameter int FAST_HALF    = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           mode_pins,
  input  logic                 cclk_in,
  input  logic                 din,
  output logic                 cclk_out,
  output logic                 cclk_oe,
  output logic                 dout,
  output logic                 load_done,
  output logic [LOAD_BITS-1:0] cfg_word
);

  clk_role_e role;
  logic      leader;
  logic      gen_rise;
  logic      fast_req;
  logic      fast_sel;
  logic      bit_stb;
  logic      bit_val;

  cfgload_mode_dec u_mode (
    .clk       (clk),
    .rst       (rst),
    .mode_pins (mode_pins),
    .role      (role)
  );

  assign leader  = (role == ROLE_LEADER);
  assign cclk_oe = leader;

  cfgload_clkgen #(
    .SLOW_HALF (SLOW_HALF),
    .FAST_HALF (FAST_HALF)
  ) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .run      (leader),
    .fast_req (fast_req),
    .cclk     (cclk_out),
    .rise     (gen_rise),
    .fast_sel (fast_sel)
  );

  cfgload_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk      (clk),
    .rst      (rst),
    .leader   (leader),
    .gen_rise (gen_rise),
    .cclk_in  (cclk_in),
    .din      (din),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val)
  );

  cfgload_shifter #(
    .LOAD_BITS    (LOAD_BITS),
    .FAST_BIT_IDX (FAST_BIT_IDX)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .word     (cfg_word),
    .done     (load_done),
    .dout     (dout),
    .fast_req (fast_req)
  );

endmodule

// File: rtl/cfgload_chk.sv
module cfgload_chk #(
  parameter int LOAD_BITS = 16,
  parameter int FAST_HALF = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 done,
  input logic                 dout,
  input logic                 cclk_out,
  input logic                 cclk_oe,
  input logic [LOAD_BITS-1:0] word,
  input logic                 fast_sel
);

  logic [15:0] run_len;
  logic        last_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len  <= 16'd1;
      last_lvl <= 1'b0;
    end else begin
      last_lvl <= cclk_out;
      if (cclk_out != last_lvl) run_len <= 16'd1;
      else if (run_len != 16'hFFFF) run_len <= run_len + 16'd1;
    end
  end

  a_r3_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  a_r4_dout_quiet_before_done: assert property (@(posedge clk) disable iff (rst)
    !done |-> !dout);

  a_r4_word_frozen: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> $stable(word));

  a_r1_follower_clock_low: assert property (@(posedge clk) disable iff (rst)
    !cclk_oe |=> !cclk_out);

  a_r7_min_phase: assert property (@(posedge clk) disable iff (rst)
    (cclk_out != last_lvl) |-> (run_len >= 16'(FAST_HALF)));

  a_r7_switch_on_fall: assert property (@(posedge clk) disable iff (rst)
    (fast_sel != $past(fast_sel)) |-> (!cclk_out && $past(cclk_out)));

  a_r8_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!done && !dout && !cclk_out && !fast_sel && word == '0));

endmodule

bind cfgload_top cfgload_chk #(
  .LOAD_BITS (LOAD_BITS),
  .FAST_HALF (FAST_HALF)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .done     (load_done),
  .dout     (dout),
  .cclk_out (cclk_out),
  .cclk_oe  (cclk_oe),
  .word     (cfg_word),
  .fast_sel (fast_sel)
);

// File: tb/cfgload_top_tb.sv
module cfgload_top_tb;

  localparam int LB   = 16;
  localparam int SLOW = 8;
  localparam int FAST = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    mode_pins = 3'b111;
  logic          cclk_in = 1'b0;
  logic          din = 1'b0;
  logic          cclk_out, cclk_oe, dout, load_done;
  logic [LB-1:0] cfg_word;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cfgload_top #(
    .LOAD_BITS (LB), .FAST_BIT_IDX (3), .SLOW_HALF (SLOW), .FAST_HALF (FAST)
  ) u_dut (
    .clk (clk), .rst (rst), .mode_pins (mode_pins), .cclk_in (cclk_in),
    .din (din), .cclk_out (cclk_out), .cclk_oe (cclk_oe), .dout (dout),
    .load_done (load_done), .cfg_word (cfg_word)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] pins);
    @(negedge clk);
    rst = 1'b1; mode_pins = pins; cclk_in = 1'b0; din = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_follower(input logic b);
    din = b; cclk_in = 1'b0;
    repeat (4) @(negedge clk);
    cclk_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_leader(input logic b, output int hi);
    while (cclk_out) @(negedge clk);
    din = b;
    while (!cclk_out) @(negedge clk);
    hi = 0;
    while (cclk_out) begin hi++; @(negedge clk); end
  endtask

  task automatic t_reset_state();
    do_reset(3'b111);
    check(load_done == 1'b0, "R8 done", load_done, 0);
    check(cfg_word == '0, "R8 word", cfg_word, 0);
    check(dout == 1'b0 && cclk_out == 1'b0, "R8 outs", {dout, cclk_out}, 0);
  endtask

  task automatic t_modes();
    int toggles;
    logic prev;
    do_reset(3'b111);
    toggles = 0; prev = cclk_out;
    repeat (40) begin @(negedge clk); if (cclk_out != prev) toggles++; prev = cclk_out; end
    check(cclk_oe == 1'b0 && toggles == 0, "R1 pins 111 follower", toggles, 0);
    do_reset(3'b101);
    toggles = 0; prev = cclk_out;
    repeat (40) begin @(negedge clk); if (cclk_out != prev) toggles++; prev = cclk_out; end
    check(cclk_oe == 1'b0 && toggles == 0, "R1 pins 101 follower", toggles, 0);
    do_reset(3'b000);
    toggles = 0; prev = cclk_out;
    repeat (40) begin @(negedge clk); if (cclk_out != prev) toggles++; prev = cclk_out; end
    check(cclk_oe == 1'b1 && toggles >= 4, "R1 pins 000 leader", toggles, 4);
  endtask

  task automatic t_follower_load();
    logic [LB-1:0] pat = 16'h1E5A;   // rate bit (index 3) is 1
    logic [3:0]    fwd = 4'b1011;
    bit            clk_quiet = 1'b1;
    do_reset(3'b111);
    for (int i = LB - 1; i >= 1; i--) begin
      send_follower(pat[i]);
      if (cclk_out) clk_quiet = 1'b0;
      if (i == 9) check(dout == 1'b0, "R4 dout low before done", dout, 0);
    end
    check(load_done == 1'b0, "R3 not done at LOAD_BITS-1", load_done, 0);
    send_follower(pat[0]);
    check(load_done == 1'b1, "R3 done at LOAD_BITS", load_done, 1);
    check(cfg_word == pat, "R2 follower word", cfg_word, pat);
    check(clk_quiet, "R1 rate bit ignored in follower", cclk_out, 0);
    for (int k = 3; k >= 0; k--) begin
      send_follower(fwd[k]);
      check(dout == fwd[k], "R4 forwarded bit", dout, fwd[k]);
    end
    check(cfg_word == pat, "R4 word frozen", cfg_word, pat);
    check(load_done == 1'b1, "R3 done holds", load_done, 1);
  endtask

  task automatic t_leader_fast();
    logic [LB-1:0] pat = 16'hB3C5;   // index 3 = 1
    int hi;
    do_reset(3'b000);
    for (int i = LB - 1; i >= 0; i--) begin
      send_leader(pat[i], hi);
      if (i == LB - 1) check(hi == SLOW, "R5 first high slow", hi, SLOW);
      if (i == LB - 4) check(hi == SLOW, "R6 rate bit phase still slow", hi, SLOW);
      if (i == LB - 5) check(hi == FAST, "R6 next phase fast", hi, FAST);
    end
    check(load_done == 1'b1, "R3 leader done", load_done, 1);
    check(cfg_word == pat, "R2 leader word", cfg_word, pat);
    send_leader(1'b1, hi);
    check(dout == 1'b1, "R4 leader forward 1", dout, 1);
    send_leader(1'b0, hi);
    check(dout == 1'b0, "R4 leader forward 0", dout, 0);
    check(hi == FAST, "R7 fast rate holds", hi, FAST);
    // reset in the middle of a fast-rate stream
    do_reset(3'b000);
    check(load_done == 1'b0 && cfg_word == '0, "R8 cleared after fast", cfg_word, 0);
    send_leader(1'b0, hi);
    check(hi == SLOW, "R8 back to slow", hi, SLOW);
  endtask

  task automatic t_leader_slow();
    logic [LB-1:0] pat = 16'h4D2E;   // index 3 = 0
    int hi;
    int worst = SLOW;
    do_reset(3'b000);
    for (int i = LB - 1; i >= 0; i--) begin
      send_leader(pat[i], hi);
      if (hi != SLOW) worst = hi;
    end
    check(worst == SLOW, "R6 zero rate bit keeps slow", worst, SLOW);
    check(cfg_word == pat, "R2 leader slow word", cfg_word, pat);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_modes();
    t_follower_load();
    t_leader_fast();
    t_leader_slow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule